// File: doc/BRIEF.md
# Two-wire bus master transmitter with status codes

This block drives a two-wire serial bus as the only master in the transmit direction. A host sees two write-only registers, selected by one address bit, plus read-back buses for control and status. The host enables the block and asks for a START. The block waits until both bus lines are seen high, then issues the START. It then parks with SCL low, raises an event flag and posts an 8-bit status code.

Each later step is also gated by the host. The host loads the data register with a byte, either the 7-bit slave address with a low write bit or a data byte, and then writes a 1 to the flag position. The block shifts the byte out most significant bit first and samples the slave's reply on the ninth clock. It then parks again with a new code. To finish, the host clears the flag with the stop request set. A lost bus (the block sends a 1 but reads a 0) is reported with its own code, and the block gives up the lines.

SCL timing comes from the system clock through a divider that the host can set. Each quarter of an SCL period lasts `scl_div + 1` clocks.

Top module: `twi_mtx_ctrl`

## Requirements
- R1: After reset both line outputs are 1 (released), status reads 0xF8, the control read-back is 0x00 and `irq_o` is 0.
- R2: With enable (control bit 2) and start (bit 5) set and the flag clear, a START (SDA falling while SCL stays high) is produced only while `scl_i` and `sda_i` are both seen high. The start bit is cleared by hardware once the START is done.
- R3: When the START completes, the flag (control bit 7) goes to 1 and status reads 0x08.
- R4: The flag is cleared only by a control write with bit 7 set, and never by hardware. While the flag is set, SCL and SDA do not move and SCL is held low.
- R5: Bytes are sent most significant bit first. Within a byte, SDA changes only while SCL is low. The ninth clock reads the slave's reply: low means ACK, high means NACK.
- R6: After an address byte the status is 0x18 on ACK and 0x20 on NACK. After a data byte it is 0x28 on ACK and 0x30 on NACK.
- R7: If the block sends a 1 but reads `sda_i` low at the sample point, it sets the flag with status 0x38, releases both lines and returns to idle.
- R8: A data-register write (`wr_sel`=1) while the flag is clear sets the collision bit (control bit 3) and leaves the register unchanged. A data write while the flag is set stores the byte and clears the collision bit.
- R9: A flag-clearing write that also has stop (bit 4) set makes the block produce a STOP (SDA rising while SCL is high). Hardware then clears the stop bit and leaves the flag clear.
- R10: `irq_o` is the flag ANDed with interrupt enable (control bit 0).
- R11: During a byte, SCL high and SCL low each last 2*(`scl_div`+1) clocks.
- R12: Whenever the flag is clear, status reads 0xF8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Host register write strobe |
| wr_sel | input | 1 | 0 selects control, 1 selects data register |
| wr_data | input | 8 | Host write value |
| scl_div | input | DIV_W | Quarter-period divider for SCL |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level |
| scl_o | output | 1 | SCL drive, 0 pulls low, 1 releases |
| sda_o | output | 1 | SDA drive, 0 pulls low, 1 releases |
| ctrl_o | output | 8 | Control read-back {flag,0,start,stop,wcol,en,0,ie} |
| status_o | output | 8 | Status code |
| irq_o | output | 1 | Interrupt request |

## Verification
Two events can land on the same clock edge: the host's data-register write and the hardware raising the flag at the end of a byte. The bench provokes this by writing a junk value on every cycle of a transfer. It drops the strobe at the first sample that shows the flag, so the last captured write is the one that met the flag's rising edge. The result is judged at the ports. The collision bit must read 1 together with the new status. After a flag clear with no fresh write, the next byte on the bus must repeat the byte sent before it, not the junk value.

// File: rtl/twi_mtx_pkg.sv
`timescale 1ns/1ps
package twi_mtx_pkg;
    localparam int BYTE_W = 8;

    localparam logic [7:0] ST_START     = 8'h08;
    localparam logic [7:0] ST_ADDR_ACK  = 8'h18;
    localparam logic [7:0] ST_ADDR_NACK = 8'h20;
    localparam logic [7:0] ST_DATA_ACK  = 8'h28;
    localparam logic [7:0] ST_DATA_NACK = 8'h30;
    localparam logic [7:0] ST_ARB_LOST  = 8'h38;
    localparam logic [7:0] ST_NONE      = 8'hF8;

    localparam int CB_FLAG  = 7;
    localparam int CB_START = 5;
    localparam int CB_STOP  = 4;
    localparam int CB_EN    = 2;
    localparam int CB_IE    = 0;

    typedef enum logic [2:0] {
        S_IDLE, S_STA_A, S_STA_B, S_HOLD, S_BIT, S_STO_A, S_STO_B, S_STO_C
    } mst_state_e;

    typedef struct packed {
        logic flag;
        logic start;
        logic stop;
        logic wcol;
        logic en;
        logic ie;
    } ctrl_t;

    function automatic logic [7:0] byte_code(input logic is_addr, input logic acked);
        if (is_addr) return acked ? ST_ADDR_ACK : ST_ADDR_NACK;
        return acked ? ST_DATA_ACK : ST_DATA_NACK;
    endfunction

    function automatic logic [7:0] pack_ctrl(input ctrl_t c);
        return {c.flag, 1'b0, c.start, c.stop, c.wcol, c.en, 1'b0, c.ie};
    endfunction
endpackage

// File: rtl/twi_mtx_tick.sv
`timescale 1ns/1ps
module twi_mtx_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == div);

    always_ff @(posedge clk) begin
        if (rst || !run || tick) cnt <= '0;
        else                     cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/twi_mtx_shift.sv
`timescale 1ns/1ps
module twi_mtx_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] din,
    input  logic         step,
    output logic         bit_o,
    output logic         ack_slot
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  sr;
    logic [CW-1:0] idx;

    assign ack_slot = (idx == CW'(W));
    assign bit_o    = ack_slot ? 1'b1 : sr[W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sr  <= '0;
            idx <= '0;
        end else if (load) begin
            sr  <= din;
            idx <= '0;
        end else if (step) begin
            sr  <= {sr[W-2:0], 1'b1};
            idx <= idx + 1'b1;
        end
    end
endmodule

// File: rtl/twi_mtx_ctrl.sv
`timescale 1ns/1ps
module twi_mtx_ctrl
    import twi_mtx_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [7:0]       wr_data,
    input  logic [DIV_W-1:0] scl_div,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             scl_o,
    output logic             sda_o,
    output logic [7:0]       ctrl_o,
    output logic [7:0]       status_o,
    output logic             irq_o
);
    mst_state_e  st;
    ctrl_t       cr;
    logic [BYTE_W-1:0] dreg;
    logic [7:0]  stat_q;
    logic [7:0]  set_code;
    logic [1:0]  ph;
    logic        is_addr, samp, scl_q, sda_q;
    logic        tick, run, sh_load, sh_step, sh_bit, sh_ack;
    logic        ctrl_wr, data_wr, start_go, sta_done, lost, byte_end, set_flag;

    assign ctrl_wr  = wr_en && !wr_sel;
    assign data_wr  = wr_en && wr_sel;
    assign run      = (st != S_IDLE) && (st != S_HOLD);
    assign start_go = (st == S_IDLE) && cr.en && cr.start && !cr.flag && scl_i && sda_i;
    assign sta_done = cr.en && (st == S_STA_B) && tick;
    assign lost     = cr.en && (st == S_BIT) && tick && (ph == 2'd3) && !sh_ack && sda_q && !samp;
    assign byte_end = cr.en && (st == S_BIT) && tick && (ph == 2'd3) && sh_ack;
    assign sh_step  = (st == S_BIT) && tick && (ph == 2'd3) && !sh_ack && !lost;
    assign sh_load  = (st == S_HOLD) && !cr.flag && !cr.stop;
    assign set_flag = sta_done || lost || byte_end;

    always_comb begin
        if (st == S_STA_B) set_code = ST_START;
        else if (lost)     set_code = ST_ARB_LOST;
        else               set_code = byte_code(is_addr, !samp);
    end

    twi_mtx_tick #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst(rst), .run(run), .div(scl_div), .tick(tick)
    );

    twi_mtx_shift #(.W(BYTE_W)) u_shift (
        .clk(clk), .rst(rst), .load(sh_load), .din(dreg), .step(sh_step),
        .bit_o(sh_bit), .ack_slot(sh_ack)
    );

    // host-visible registers; hardware events take priority
    always_ff @(posedge clk) begin
        if (rst) begin
            cr     <= '0;
            dreg   <= '0;
            stat_q <= ST_NONE;
        end else begin
            if (ctrl_wr) begin
                cr.en    <= wr_data[CB_EN];
                cr.ie    <= wr_data[CB_IE];
                cr.start <= wr_data[CB_START];
                cr.stop  <= wr_data[CB_STOP];
                if (wr_data[CB_FLAG]) cr.flag <= 1'b0;
            end
            if (data_wr) begin
                cr.wcol <= !cr.flag;
                if (cr.flag) dreg <= wr_data;
            end
            if (set_flag)
                stat_q <= set_code;
            else if (ctrl_wr && wr_data[CB_FLAG])
                stat_q <= ST_NONE;
            if (set_flag) cr.flag <= 1'b1;
            if (sta_done) cr.start <= 1'b0;
            if (st == S_STO_C && tick) cr.stop <= 1'b0;
        end
    end

    // bus sequencer
    always_ff @(posedge clk) begin
        if (rst || !cr.en) begin
            st      <= S_IDLE;
            ph      <= '0;
            is_addr <= 1'b0;
            samp    <= 1'b1;
            scl_q   <= 1'b1;
            sda_q   <= 1'b1;
        end else begin
            unique case (st)
                S_IDLE:  if (start_go) st <= S_STA_A;
                S_STA_A: if (tick) begin sda_q <= 1'b0; st <= S_STA_B; end
                S_STA_B: if (tick) begin scl_q <= 1'b0; is_addr <= 1'b1; st <= S_HOLD; end
                S_HOLD: begin
                    if (!cr.flag) begin
                        ph <= '0;
                        st <= cr.stop ? S_STO_A : S_BIT;
                    end
                end
                S_BIT: begin
                    if (tick) begin
                        ph <= ph + 1'b1;
                        unique case (ph)
                            2'd0: sda_q <= sh_bit;
                            2'd1: scl_q <= 1'b1;
                            2'd2: samp  <= sda_i;
                            2'd3: begin
                                scl_q <= 1'b0;
                                if (lost) begin
                                    scl_q <= 1'b1;
                                    sda_q <= 1'b1;
                                    st    <= S_IDLE;
                                end else if (sh_ack) begin
                                    is_addr <= 1'b0;
                                    st      <= S_HOLD;
                                end
                            end
                        endcase
                    end
                end
                S_STO_A: if (tick) begin sda_q <= 1'b0; st <= S_STO_B; end
                S_STO_B: if (tick) begin scl_q <= 1'b1; st <= S_STO_C; end
                S_STO_C: if (tick) begin sda_q <= 1'b1; st <= S_IDLE; end
                default: st <= S_IDLE;
            endcase
        end
    end

    assign scl_o    = scl_q;
    assign sda_o    = sda_q;
    assign ctrl_o   = pack_ctrl(cr);
    assign status_o = stat_q;
    assign irq_o    = cr.flag && cr.ie;
endmodule

// File: rtl/twi_mtx_chk.sv
`timescale 1ns/1ps
module twi_mtx_chk
    import twi_mtx_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       clr_req,
    input logic       dat_wr,
    input logic       scl_o,
    input logic       sda_o,
    input logic       flag,
    input logic       wcol,
    input logic       en,
    input logic [7:0] status,
    input logic [7:0] dreg,
    input mst_state_e st
);
    AST_START_EDGE: assert property (@(posedge clk) disable iff (rst)
        (scl_o && $past(scl_o) && $fell(sda_o)) |-> ($past(st) == S_STA_A)); // R2

    AST_CODE_POSTED: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> (status != ST_NONE)); // R3

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr_req) |=> flag); // R4

    AST_LINES_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (flag && en) |=> (!flag || !en || ($stable(scl_o) && $stable(sda_o)))); // R4

    AST_SDA_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        ((st == S_BIT) && ($past(st) == S_BIT) && !$stable(sda_o)) |-> (!scl_o && !$past(scl_o))); // R5

    AST_COLLISION: assert property (@(posedge clk) disable iff (rst)
        (dat_wr && !flag) |=> (wcol && $stable(dreg))); // R8

    AST_STOP_EDGE: assert property (@(posedge clk) disable iff (rst)
        (scl_o && $past(scl_o) && $rose(sda_o)) |-> ((($past(st) == S_STO_C) && !flag) || !$past(en))); // R9

    AST_IDLE_STATUS: assert property (@(posedge clk) disable iff (rst)
        !flag |-> (status == ST_NONE)); // R12
endmodule

bind twi_mtx_ctrl twi_mtx_chk u_chk (
    .clk(clk), .rst(rst),
    .clr_req(wr_en && !wr_sel && wr_data[7]),
    .dat_wr(wr_en && wr_sel),
    .scl_o(scl_o), .sda_o(sda_o),
    .flag(ctrl_o[7]), .wcol(ctrl_o[3]), .en(ctrl_o[2]),
    .status(status_o), .dreg(dreg), .st(st)
);

// File: tb/twi_mtx_ctrl_tb.sv
`timescale 1ns/1ps
module twi_mtx_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0, wr_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] scl_div = 8'd3;
    logic       scl_o, sda_o, irq_o;
    logic [7:0] ctrl_o, status_o;
    logic       slv_sda = 1'b1, force_sda = 1'b1, slv_ack = 1'b1, ie_m = 1'b0;
    wire        sda_line = sda_o & slv_sda & force_sda;
    wire        scl_line = scl_o;

    int vectors = 0, miscompares = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    twi_mtx_ctrl u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .scl_div(scl_div), .scl_i(scl_line), .sda_i(sda_line),
        .scl_o(scl_o), .sda_o(sda_o), .ctrl_o(ctrl_o), .status_o(status_o), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // bus monitor and acknowledging slave model
    logic       p_scl, p_sda;
    logic [7:0] shreg;
    logic [7:0] rx_q[$];
    int bitn, starts, stops, rises, hi_cnt, last_hi;

    always @(negedge clk) begin
        if (rst) begin
            p_scl = 1'b1; p_sda = 1'b1; bitn = 0; starts = 0; stops = 0;
            rises = 0; hi_cnt = 0; last_hi = 0; shreg = 8'h00;
        end else begin
            if (p_scl && scl_line && p_sda && !sda_line) begin starts++; bitn = 0; end
            if (p_scl && scl_line && !p_sda && sda_line) begin stops++;  bitn = 0; end
            if (!p_scl && scl_line) begin
                rises++;
                if (bitn < 8) begin
                    shreg = {shreg[6:0], sda_line};
                    if (bitn == 7) rx_q.push_back(shreg);
                end
                bitn++;
            end
            if (p_scl && !scl_line) begin
                if (bitn == 8) slv_sda = !slv_ack;
                else if (bitn == 9) begin slv_sda = 1'b1; bitn = 0; end
            end
            if (scl_line) hi_cnt++;
            else begin
                if (p_scl) last_hi = hi_cnt;
                hi_cnt = 0;
            end
            chk("R10 irq", irq_o, ctrl_o[7] & ie_m);
            if (!ctrl_o[7]) chk("R12 idle status", status_o, 8'hF8);
            p_scl = scl_line;
            p_sda = sda_line;
        end
    end

    task automatic wr(input logic sel, input logic [7:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
        if (!sel) ie_m = d[0];
    endtask

    task automatic wait_flag(input string req);
        int n = 0;
        while (!ctrl_o[7] && n < 5000) begin @(negedge clk); n++; end
        chk(req, ctrl_o[7], 1'b1);
    endtask

    task automatic wait_stop(input int s0);
        int n = 0;
        while (stops == s0 && n < 5000) begin @(negedge clk); n++; end
        repeat (3) @(negedge clk);
    endtask

    task automatic chk_byte(input string req, input logic [7:0] exp);
        if (rx_q.size() == 0) chk(req, 32'hFFFF, exp);
        else chk(req, rx_q.pop_front(), exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        int s0, r0;
        repeat (4) @(posedge clk); #1 rst = 1'b0;
        @(negedge clk);
        chk("R1 status", status_o, 8'hF8);
        chk("R1 ctrl", ctrl_o, 8'h00);
        chk("R1 lines", {scl_o, sda_o}, 2'b11);
        chk("R1 irq", irq_o, 1'b0);

        // START, then suspension while the flag is up
        wr(1'b0, 8'h25);
        wait_flag("R3 flag after start");
        chk("R3 status", status_o, 8'h08);
        chk("R2 one start", starts, 1);
        chk("R2 start bit cleared", ctrl_o[5], 1'b0);
        chk("R10 irq up", irq_o, 1'b1);
        r0 = rises;
        repeat (40) @(negedge clk);
        chk("R4 flag sticky", ctrl_o[7], 1'b1);
        chk("R4 scl held low", scl_o, 1'b0);
        chk("R4 no clocks", rises, r0);

        // address with ACK
        wr(1'b1, 8'hA4);
        wr(1'b0, 8'h85);
        @(negedge clk);
        chk("R12 status after clear", status_o, 8'hF8);
        wait_flag("R6 flag after address");
        chk("R6 addr ack", status_o, 8'h18);
        chk_byte("R5 address bits", 8'hA4);
        chk("R11 scl high div3", last_hi, 8);

        // data with ACK, then data with NACK
        wr(1'b1, 8'h3C); wr(1'b0, 8'h85);
        wait_flag("R6 flag data");
        chk("R6 data ack", status_o, 8'h28);
        chk_byte("R5 data bits", 8'h3C);
        slv_ack = 1'b0;
        wr(1'b1, 8'hFF); wr(1'b0, 8'h85);
        wait_flag("R6 flag data nack");
        chk("R6 data nack", status_o, 8'h30);
        chk_byte("R5 data ones", 8'hFF);
        slv_ack = 1'b1;

        // write collision meeting the flag's rising edge
        wr(1'b1, 8'h5A); wr(1'b0, 8'h85);
        for (int i = 0; i < 4000; i++) begin
            @(posedge clk); #1;
            wr_en = 1'b1; wr_sel = 1'b1; wr_data = 8'hC3;
            @(negedge clk);
            if (ctrl_o[7]) begin wr_en = 1'b0; break; end
        end
        wr_en = 1'b0;
        chk("R8 wcol with flag", ctrl_o[3], 1'b1);
        chk("R6 status collide", status_o, 8'h28);
        chk_byte("R5 byte under writes", 8'h5A);
        wr(1'b0, 8'h85);
        wait_flag("R8 flag resend");
        chk_byte("R8 register unchanged", 8'h5A);
        wr(1'b1, 8'h11);
        @(negedge clk);
        chk("R8 wcol cleared", ctrl_o[3], 1'b0);

        // STOP
        s0 = stops;
        wr(1'b0, 8'h95);
        wait_stop(s0);
        chk("R9 stop seen", stops, s0 + 1);
        chk("R9 flag clear", ctrl_o[7], 1'b0);
        chk("R9 stop bit cleared", ctrl_o[4], 1'b0);
        chk("R9 lines released", {scl_o, sda_o}, 2'b11);

        // faster clock, address NACK
        scl_div = 8'd1;
        wr(1'b0, 8'h25);
        wait_flag("R3 second start");
        chk("R3 status again", status_o, 8'h08);
        slv_ack = 1'b0;
        wr(1'b1, 8'h90); wr(1'b0, 8'h85);
        wait_flag("R6 flag addr nack");
        chk("R6 addr nack", status_o, 8'h20);
        chk("R11 scl high div1", last_hi, 4);
        chk_byte("R5 addr 90", 8'h90);
        slv_ack = 1'b1;
        s0 = stops;
        wr(1'b0, 8'h95);
        wait_stop(s0);

        // arbitration loss
        wr(1'b0, 8'h25);
        wait_flag("R3 third start");
        force_sda = 1'b0;
        wr(1'b1, 8'hC0); wr(1'b0, 8'h85);
        wait_flag("R7 flag arb");
        chk("R7 arb status", status_o, 8'h38);
        @(negedge clk);
        chk("R7 lines released", {scl_o, sda_o}, 2'b11);
        force_sda = 1'b1;
        void'(rx_q.size());
        rx_q.delete();
        wr(1'b0, 8'h85);
        @(negedge clk);
        chk("R4 flag cleared by write", ctrl_o[7], 1'b0);

        // busy bus holds the START back
        force_sda = 1'b0;
        wr(1'b0, 8'h25);
        repeat (60) @(negedge clk);
        chk("R2 no start on busy", ctrl_o[7], 1'b0);
        chk("R2 start pending", ctrl_o[5], 1'b1);
        chk("R2 sda untouched", sda_o, 1'b1);
        s0 = starts;
        force_sda = 1'b1;
        wait_flag("R2 start after free");
        chk("R2 status free", status_o, 8'h08);
        chk("R2 start count", starts, s0 + 1);

        // interrupt enable off while flag is up
        wr(1'b0, 8'h04);
        @(negedge clk);
        chk("R10 irq masked", irq_o, 1'b0);
        chk("R4 flag kept", ctrl_o[7], 1'b1);
        s0 = stops;
        wr(1'b0, 8'h94);
        wait_stop(s0);
        chk("R9 second stop", stops, s0 + 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule